// File: doc/BRIEF.md
# Sleep Entry Power Sequencer

This block is a hardware state machine that takes a system down into a low-power sleep state without software help. It acts as the only master on a simple register bus, with address, write data, read data and a valid/ready handshake. It carries out a fixed list of register reads and writes that stop the memory controller and put the DRAM into self-refresh. It then parks the memory pads at safe levels, moves the CPU and system clocks off the PLLs, turns the PLLs off and finally drops the system clock to the 32 kHz source.

A one-cycle `start` pulse launches the sequence. A free-running microsecond timer input sets the minimum settling gap between the clock switch and the first PLL access. The pad values and the system-clock policy that were in place before the sequence are kept in internal registers. They are driven on outputs so that a matching resume sequencer can restore them. `done` rises when the last write has been accepted and stays high until the next accepted start.

Top module: `sleep_entry_seq`

## Requirements
- R1: After reset `busy`, `done` and `bus_valid` are low, and `bus_valid` stays low whenever the block is idle.
- R2: An accepted start first writes 3 to the request-control register (0x000). The block then reads the status register (0x004) until its bit 2 is 1, then writes 1 to the self-refresh register (0x008).
- R3: The block next reads the address-config register (0x00C). If bits 25:24 of that value are both zero, the acknowledge mask is bit 8; otherwise it is bits 9:8. The block then reads the status register until every mask bit is set, and a partial acknowledge does not end the wait.
- R4: The seven pad registers lie at 0x200 + 4*i for i = 0 to 6, in ascending order. Each one is read, and then written with its safe value, taken in turn from 0x8, 0x8, 0x0, 0x8, 0x5500, 0x08080040, 0x0. The read value for pad i appears on `pad_save` bits 32*i+31 : 32*i.
- R5: The block reads the system-clock policy register (0x100) and drives that value on `sclk_save`. It then writes 0x10000000 to 0x100 and to the CPU policy register 0x104, then 0 to the CPU divider 0x10C, then 0 to the system divider 0x108.
- R6: At least WAIT_US (2) timer counts pass between acceptance of the system-divider write and the first PLL access, and this holds across timer wrap-around.
- R7: The three PLL registers at 0x110, 0x114 and 0x118 are handled in that order. Each is read and then written back with bit 30 cleared and every other bit unchanged.
- R8: The final bus access writes 0 to 0x100. `done` then rises, `busy` falls, no further access follows, and `done` stays high until the next accepted start clears it.
- R9: Only one access is in flight at a time. While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` hold their values.
- R10: A start pulse that arrives while the sequence is running has no effect: no access is repeated or added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin the sleep-entry sequence |
| tmr_us | input | TW (32) | Free-running microsecond count |
| bus_valid | output | 1 | Access request |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW (12) | Byte address of the access |
| bus_wdata | output | DW (32) | Write data |
| bus_rdata | input | DW (32) | Read data, sampled on the edge where valid and ready are both high |
| bus_ready | input | 1 | Slave accepts the current access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed; held until the next start |
| pad_save | output | NPAD*DW (224) | Pad values captured before the safe values were written |
| sclk_save | output | DW (32) | System-clock policy captured before the clock switch |

## Verification
An access completes on the rising edge where valid and ready are both high. The slave model drives ready and read data half a cycle before that edge, so a captured value shows on `pad_save` or `sclk_save` by the following falling edge. `done` rises one edge after the final write is accepted. `busy` falls on that same edge, and the first access after a start is presented one edge after the start is taken. The bench advances on falling edges and samples 1 ns later, so every check reads values that were settled at the preceding rising edge. The bench logs accesses by their timer value at acceptance, so the settling-gap check compares counts the design also saw, including one case where the timer wraps.

// File: rtl/sleep_entry_seq.sv
module sleep_entry_seq #(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int TW      = 32,
  parameter int NPAD    = 7,
  parameter int NPLL    = 3,
  parameter int WAIT_US = 2,
  parameter logic [AW-1:0] A_REQ    = 'h000,
  parameter logic [AW-1:0] A_STAT   = 'h004,
  parameter logic [AW-1:0] A_SREF   = 'h008,
  parameter logic [AW-1:0] A_ADRCFG = 'h00C,
  parameter logic [AW-1:0] A_SYSB   = 'h100,
  parameter logic [AW-1:0] A_CPUB   = 'h104,
  parameter logic [AW-1:0] A_SYSDIV = 'h108,
  parameter logic [AW-1:0] A_CPUDIV = 'h10C,
  parameter logic [AW-1:0] PLL_BASE = 'h110,
  parameter logic [AW-1:0] PAD_BASE = 'h200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TW-1:0]      tmr_us,
  output logic               bus_valid,
  output logic               bus_write,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  input  logic               bus_ready,
  output logic               busy,
  output logic               done,
  output logic [NPAD*DW-1:0] pad_save,
  output logic [DW-1:0]      sclk_save
);
  localparam int IW = $clog2((NPAD > NPLL ? NPAD : NPLL) + 1);
  localparam logic [DW-1:0] XTAL   = DW'(32'h1000_0000);
  localparam logic [DW-1:0] PLL_EN = DW'(32'h4000_0000);

  typedef enum logic [4:0] {
    ST_IDLE, ST_STALL, ST_IDLEPOLL, ST_SREF, ST_CFG, ST_SRPOLL,
    ST_PADRD, ST_PADWR, ST_SCRD, ST_SYSX, ST_CPUX, ST_CPUDIV,
    ST_SYSDIV, ST_WAIT, ST_PLLRD, ST_PLLWR, ST_S32
  } st_t;

  st_t            state;
  logic [IW-1:0]  idx;
  logic [1:0]     mask;
  logic [DW-1:0]  tmp;
  logic [TW-1:0]  t0;
  logic [DW-1:0]  pad_q [NPAD];
  logic           xfer;

  function automatic logic [AW-1:0] word(input logic [AW-1:0] base, input logic [IW-1:0] i);
    return base + AW'({i, 2'b00});
  endfunction

  function automatic logic [DW-1:0] safe_val(input logic [IW-1:0] i);
    case (int'(i))
      0, 1, 3: return DW'(32'h0000_0008);
      4:       return DW'(32'h0000_5500);
      5:       return DW'(32'h0808_0040);
      default: return '0;
    endcase
  endfunction

  assign xfer = bus_valid && bus_ready;
  assign busy = (state != ST_IDLE);

  for (genvar g = 0; g < NPAD; g++) begin : g_pad
    assign pad_save[g*DW +: DW] = pad_q[g];
  end

  always_comb begin
    bus_valid = 1'b1;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      ST_STALL:    begin bus_write = 1'b1; bus_addr = A_REQ;  bus_wdata = DW'(3); end
      ST_IDLEPOLL: bus_addr = A_STAT;
      ST_SREF:     begin bus_write = 1'b1; bus_addr = A_SREF; bus_wdata = DW'(1); end
      ST_CFG:      bus_addr = A_ADRCFG;
      ST_SRPOLL:   bus_addr = A_STAT;
      ST_PADRD:    bus_addr = word(PAD_BASE, idx);
      ST_PADWR:    begin bus_write = 1'b1; bus_addr = word(PAD_BASE, idx); bus_wdata = safe_val(idx); end
      ST_SCRD:     bus_addr = A_SYSB;
      ST_SYSX:     begin bus_write = 1'b1; bus_addr = A_SYSB;   bus_wdata = XTAL; end
      ST_CPUX:     begin bus_write = 1'b1; bus_addr = A_CPUB;   bus_wdata = XTAL; end
      ST_CPUDIV:   begin bus_write = 1'b1; bus_addr = A_CPUDIV; end
      ST_SYSDIV:   begin bus_write = 1'b1; bus_addr = A_SYSDIV; end
      ST_PLLRD:    bus_addr = word(PLL_BASE, idx);
      ST_PLLWR:    begin bus_write = 1'b1; bus_addr = word(PLL_BASE, idx); bus_wdata = tmp & ~PLL_EN; end
      ST_S32:      begin bus_write = 1'b1; bus_addr = A_SYSB; end
      default:     bus_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      mask      <= '0;
      tmp       <= '0;
      t0        <= '0;
      done      <= 1'b0;
      sclk_save <= '0;
      for (int i = 0; i < NPAD; i++) pad_q[i] <= '0;
    end else begin
      case (state)
        ST_IDLE:     if (start) begin state <= ST_STALL; done <= 1'b0; end
        ST_STALL:    if (xfer) state <= ST_IDLEPOLL;
        ST_IDLEPOLL: if (xfer && bus_rdata[2]) state <= ST_SREF;
        ST_SREF:     if (xfer) state <= ST_CFG;
        ST_CFG:      if (xfer) begin
                       mask  <= (bus_rdata[25:24] == 2'b00) ? 2'b01 : 2'b11;
                       state <= ST_SRPOLL;
                     end
        ST_SRPOLL:   if (xfer && ((bus_rdata[9:8] & mask) == mask)) begin
                       idx <= '0; state <= ST_PADRD;
                     end
        ST_PADRD:    if (xfer) begin pad_q[idx] <= bus_rdata; state <= ST_PADWR; end
        ST_PADWR:    if (xfer) begin
                       if (idx == IW'(NPAD-1)) state <= ST_SCRD;
                       else begin idx <= idx + 1'b1; state <= ST_PADRD; end
                     end
        ST_SCRD:     if (xfer) begin sclk_save <= bus_rdata; state <= ST_SYSX; end
        ST_SYSX:     if (xfer) state <= ST_CPUX;
        ST_CPUX:     if (xfer) state <= ST_CPUDIV;
        ST_CPUDIV:   if (xfer) state <= ST_SYSDIV;
        ST_SYSDIV:   if (xfer) begin t0 <= tmr_us; state <= ST_WAIT; end
        ST_WAIT:     if ((tmr_us - t0) >= TW'(WAIT_US)) begin idx <= '0; state <= ST_PLLRD; end
        ST_PLLRD:    if (xfer) begin tmp <= bus_rdata; state <= ST_PLLWR; end
        ST_PLLWR:    if (xfer) begin
                       if (idx == IW'(NPLL-1)) state <= ST_S32;
                       else begin idx <= idx + 1'b1; state <= ST_PLLRD; end
                     end
        ST_S32:      if (xfer) begin done <= 1'b1; state <= ST_IDLE; end
        default:     state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sleep_entry_seq_chk.sv
module sleep_entry_seq_chk #(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int TW      = 32,
  parameter int NPLL    = 3,
  parameter int WAIT_US = 2,
  parameter logic [AW-1:0] A_REQ    = 'h000,
  parameter logic [AW-1:0] A_SYSB   = 'h100,
  parameter logic [AW-1:0] A_SYSDIV = 'h108,
  parameter logic [AW-1:0] PLL_BASE = 'h110
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [TW-1:0] tmr_us,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          busy,
  input logic          done
);
  logic [TW-1:0] t_div;
  logic          seen_div;
  logic          last_wr;
  logic          in_pll;

  assign last_wr = bus_valid && bus_ready && bus_write && bus_addr == A_SYSB && bus_wdata == '0;
  assign in_pll  = bus_addr >= PLL_BASE && bus_addr < PLL_BASE + AW'(4*NPLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_div    <= '0;
      seen_div <= 1'b0;
    end else if (bus_valid && bus_ready && bus_write && bus_addr == A_SYSDIV) begin
      t_div    <= tmr_us;
      seen_div <= 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

  // R2
  first_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_valid && bus_write && bus_addr == A_REQ && bus_wdata == DW'(3));

  // R6
  pll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_div && bus_valid && !bus_write && bus_addr == PLL_BASE |-> (tmr_us - t_div) >= TW'(WAIT_US));

  // R7
  pll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && in_pll |-> !bus_wdata[30]);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_wr) && !busy);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));

  // R10
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !last_wr |=> busy);
endmodule

bind sleep_entry_seq sleep_entry_seq_chk #(
  .AW(AW), .DW(DW), .TW(TW), .NPLL(NPLL), .WAIT_US(WAIT_US),
  .A_REQ(A_REQ), .A_SYSB(A_SYSB), .A_SYSDIV(A_SYSDIV), .PLL_BASE(PLL_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tmr_us(tmr_us),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready), .busy(busy), .done(done)
);

// File: tb/sleep_entry_seq_bench.sv
`timescale 1ns/1ps
module sleep_entry_seq_bench;
  localparam int NTR  = 29;
  localparam int TICK = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  tmr_us = '0;
  logic         bus_valid, bus_write;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata = '0;
  logic         bus_ready = 1'b0;
  logic         busy, done;
  logic [223:0] pad_save;
  logic [31:0]  sclk_save;

  sleep_entry_seq u_sleep_entry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tmr_us(tmr_us),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .done(done), .pad_save(pad_save), .sclk_save(sclk_save)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  int n_tr, idle_polls, sref_polls, idle_a, b8_a, b9_a;
  bit sref_on;
  logic        tr_w [0:63];
  logic [11:0] tr_a [0:63];
  logic [31:0] tr_d [0:63], tr_t [0:63];
  logic        ex_w [0:NTR-1];
  logic [11:0] ex_a [0:NTR-1];
  logic [31:0] ex_d [0:NTR-1];
  logic [31:0] pad_init [0:6];
  logic [31:0] pll_init [0:2];
  logic [31:0] sclk_init;
  bit          hold_prev;
  logic [11:0] hold_a;
  logic [31:0] hold_d;
  logic        hold_w;

  function automatic logic [31:0] safe_b(int i);
    case (i)
      4: return 32'h5500;
      5: return 32'h0808_0040;
      2, 6: return 32'h0;
      default: return 32'h8;
    endcase
  endfunction

  function automatic string req_of(int k);
    if (k < 2) return "R2";
    if (k == 2) return "R3";
    if (k <= 16) return "R4";
    if (k <= 21) return "R5";
    if (k <= 27) return "R7";
    return "R8";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] v;
    @(negedge clk);
    cyc++;
    if (cyc % TICK == 0) tmr_us = tmr_us + 1;
    bus_ready = ($urandom % 4) != 0;
    #1;
    if (hold_prev) begin
      chk(bus_valid && bus_addr == hold_a && bus_write == hold_w && bus_wdata == hold_d,
          "R9", "held access changed", {20'h0, bus_addr}, {20'h0, hold_a});
    end
    hold_prev = bus_valid && !bus_ready;
    hold_a = bus_addr; hold_d = bus_wdata; hold_w = bus_write;
    if (bus_valid && bus_ready) begin
      if (bus_write) begin
        mem[bus_addr[11:2]] = bus_wdata;
        if (bus_addr == 12'h008) sref_on = 1;
        v = bus_wdata;
      end else if (bus_addr == 12'h004) begin
        if (!sref_on) begin
          v = (idle_polls >= idle_a) ? 32'h4 : 32'h0;
          idle_polls++;
        end else begin
          v = 32'h4 | ((sref_polls >= b8_a) ? 32'h100 : 32'h0) | ((sref_polls >= b9_a) ? 32'h200 : 32'h0);
          sref_polls++;
        end
      end else v = mem[bus_addr[11:2]];
      if (!bus_write) bus_rdata = v;
      if (!(bus_addr == 12'h004 && !bus_write)) begin
        if (n_tr < 64) begin
          tr_w[n_tr] = bus_write; tr_a[n_tr] = bus_addr; tr_d[n_tr] = v; tr_t[n_tr] = tmr_us;
        end
        n_tr++;
      end
    end else bus_rdata = $urandom;
  endtask

  task automatic put(int k, logic w, logic [11:0] a, logic [31:0] d);
    ex_w[k] = w; ex_a[k] = a; ex_d[k] = d;
  endtask

  task automatic run_case(int ia, int b8, int b9, logic [31:0] cfg, bit poke, bit wrap);
    int k, lim, exp_sref, n_done;
    bit two;
    idle_a = ia; b8_a = b8; b9_a = b9;
    idle_polls = 0; sref_polls = 0; sref_on = 0; n_tr = 0;
    two = cfg[25:24] != 2'b00;
    if (wrap) tmr_us = 32'hFFFF_FFFE;
    mem[12'h00C >> 2] = cfg;
    sclk_init = $urandom; mem[12'h100 >> 2] = sclk_init;
    for (int i = 0; i < 7; i++) begin pad_init[i] = $urandom; mem[(12'h200 >> 2) + i] = pad_init[i]; end
    for (int i = 0; i < 3; i++) begin
      pll_init[i] = $urandom; if (i == 1) pll_init[i][30] = 1'b1;
      mem[(12'h110 >> 2) + i] = pll_init[i];
    end
    k = 0;
    put(k++, 1, 12'h000, 32'h3); put(k++, 1, 12'h008, 32'h1); put(k++, 0, 12'h00C, cfg);
    for (int i = 0; i < 7; i++) begin
      put(k++, 0, 12'(12'h200 + 4*i), pad_init[i]); put(k++, 1, 12'(12'h200 + 4*i), safe_b(i));
    end
    put(k++, 0, 12'h100, sclk_init); put(k++, 1, 12'h100, 32'h1000_0000);
    put(k++, 1, 12'h104, 32'h1000_0000); put(k++, 1, 12'h10C, 32'h0); put(k++, 1, 12'h108, 32'h0);
    for (int i = 0; i < 3; i++) begin
      put(k++, 0, 12'(12'h110 + 4*i), pll_init[i]); put(k++, 1, 12'(12'h110 + 4*i), pll_init[i] & ~32'h4000_0000);
    end
    put(k++, 1, 12'h100, 32'h0);

    start = 1'b1; step(); start = 1'b0; step();
    // R8: accepted start clears done
    chk(!done && busy, "R8", "done cleared by start", {31'h0, done}, 32'h0);
    if (poke) begin
      repeat (12) step();
      start = 1'b1; step(); start = 1'b0;
    end
    lim = 0;
    while (!done && lim < 3000) begin step(); lim++; end
    chk(done, "R8", "watchdog: done never rose", {31'h0, done}, 32'h1);
    n_done = n_tr;
    repeat (5) step();
    chk(done && !busy, "R8", "done held, busy low", {30'h0, busy, done}, 32'h1);
    chk(n_tr == n_done, "R8", "access after done", n_tr, n_done);
    // R10 and overall order: exactly the expected access count
    chk(n_tr == NTR, poke ? "R10" : "R2", "access count", n_tr, NTR);
    for (int i = 0; i < NTR && i < n_tr; i++) begin
      chk(tr_w[i] == ex_w[i] && tr_a[i] == ex_a[i] && tr_d[i] == ex_d[i], req_of(i),
          $sformatf("access %0d addr %h", i, tr_a[i]), tr_d[i], ex_d[i]);
    end
    chk(idle_polls == ia + 1, "R2", "idle poll count", idle_polls, ia + 1);
    exp_sref = two ? ((b8 > b9 ? b8 : b9) + 1) : (b8 + 1);
    chk(sref_polls == exp_sref, "R3", "self-refresh poll count", sref_polls, exp_sref);
    if (n_tr >= 23)
      chk((tr_t[22] - tr_t[21]) >= 2, "R6", "timer gap before PLL", tr_t[22] - tr_t[21], 32'd2);
    for (int i = 0; i < 7; i++)
      chk(pad_save[32*i +: 32] == pad_init[i], "R4", $sformatf("pad_save %0d", i), pad_save[32*i +: 32], pad_init[i]);
    chk(sclk_save == sclk_init, "R5", "sclk_save", sclk_save, sclk_init);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    hold_prev = 0;
    repeat (3) step();
    // R1: reset state
    chk(!busy && !done && !bus_valid, "R1", "reset outputs", {29'h0, bus_valid, busy, done}, 32'h0);
    rst_n = 1'b1;
    repeat (3) step();
    chk(!busy && !done && !bus_valid, "R1", "idle after reset", {29'h0, bus_valid, busy, done}, 32'h0);
    run_case(0, 0, 9, 32'h0000_0000, 0, 0);
    run_case(2, 0, 4, 32'h0200_1234, 0, 0);
    run_case(1, 3, 0, 32'h00FF_0000, 1, 0);
    run_case(3, 2, 2, 32'h0300_0000, 1, 1);
    for (int r = 0; r < 8; r++) begin
      logic [31:0] cfg = $urandom;
      run_case(int'($urandom % 5), int'($urandom % 5), int'($urandom % 5), cfg,
               bit'($urandom % 2), bit'($urandom % 3 == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule